// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns a decoded two-rail ARINC 429 line into complete 32-bit words. One rail pulses high for each one bit and the other rail pulses high for each zero bit. Both rails resting low is the null level between bits. The rails and a separate, slow gap clock reach the block asynchronously. All three are brought into the system clock domain before any edge is detected.

Words have no start or end markers on the wire. A word ends when the line has stayed null for a fixed number of gap clock rising edges. When a word ends, the block loads it into a receive buffer, checks the bit count and, if parity is enabled, checks odd parity. It then gives a one-cycle valid pulse with an error flag. Each bit shifts in as it arrives, so the next word can be received while downstream logic reads the buffered one.

Top module: `a429_word_rx`

## Requirements
- R1: A rising edge on `rail_one` while `rail_zero` is low records a 1. A rising edge on `rail_zero` while `rail_one` is low records a 0. The first bit received of a word lands in `word_out[0]` and the 32nd lands in `word_out[31]`.
- R2: A word ends when 16 rising edges of `gap_clk` have been counted while both rails are low. High activity on either rail restarts the count, so a null gap of only 15 edges does not split two bursts of bits.
- R3: When a word ends with at least one bit recorded, `word_out` and `word_err` are loaded and `word_valid` is high for exactly one clock cycle. A gap with no bits recorded produces no pulse.
- R4: If the number of bits recorded for a word is anything other than 32, `word_err` is high with that word.
- R5: With `parity_en` high, odd parity is checked over all 32 received bits. An even number of ones is a failure: `word_out[31]` is then 1 and `word_err` is high. On a pass, `word_out[31]` is 0 and `word_err` is low.
- R6: With `parity_en` low, `word_out[31]` carries the 32nd received bit unchanged and parity never raises `word_err`.
- R7: Raising both rails together is invalid and records no bit. The rest of the word is assembled as if that event had not occurred.
- R8: The receive buffer keeps the previous word unchanged while the next word's bits are arriving, until the next word is loaded.
- R9: Synchronous active-low reset clears `word_out`, `word_err` and `word_valid` and discards any partly received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_one | input | 1 | Asynchronous rail that pulses for a one bit |
| rail_zero | input | 1 | Asynchronous rail that pulses for a zero bit |
| gap_clk | input | 1 | Asynchronous clock used to time the null gap between words |
| parity_en | input | 1 | High to enable the odd parity check and the overwrite of bit 31 |
| word_out | output | 32 | Receive buffer holding the last completed word |
| word_valid | output | 1 | One-cycle pulse when a new word has been loaded |
| word_err | output | 1 | Bit count or parity error for the word in `word_out` |

## Verification
The hardest case to reach from the ports is the word boundary itself. A gap one edge short of the limit must not close the word: the bench sends 32 bits, exactly 15 gap clock pulses, then 32 more bits. It then expects a single pulse carrying a count error for the merged word. The bench also sends a gap with no bits, which must give no pulse, and a burst with both rails raised in the middle of a word, which must leave the data intact. Walking-one and walking-zero sweeps run in both parity modes. The expected bit 31 and error flag are computed from the population count of each word.

// File: rtl/a429_rx_pkg.sv
// Package a429_rx_pkg
// Types shared by the word receiver's submodules.
// Assumes: nothing beyond IEEE 1800-2017.
package a429_rx_pkg;

    // The two rails after synchronisation
    typedef struct packed {
        logic one;
        logic zero;
    } rails_t;

    // Bit event reported by the detector in a clock cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ZERO = 2'd1,
        EV_ONE  = 2'd2
    } bit_ev_e;

endpackage

// File: rtl/a429_sync.sv
// Module a429_sync
// Multi-stage flip-flop synchroniser for a vector of independent
// asynchronous single-bit signals.
// Assumes: each bit is slow compared to clk, so bits need no mutual coherence.
module a429_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/a429_bit_detect.sv
// Module a429_bit_detect
// Turns synchronised rail levels into bit events and a line-activity flag.
// Assumes: inputs are already in the clk domain, and a null level separates
// bits on the line.
module a429_bit_detect
    import a429_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rails_t  rails_s,
    output bit_ev_e ev,
    output logic    activity
);

    rails_t rails_q;
    logic   one_rise;
    logic   zero_rise;

    // Keep the previous rail levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rails_q <= '0;
        else        rails_q <= rails_s;
    end

    assign one_rise  = rails_s.one  & ~rails_q.one;
    assign zero_rise = rails_s.zero & ~rails_q.zero;
    assign activity  = rails_s.one | rails_s.zero;

    // Classify the edge. A rise while the other rail is high is invalid.
    always_comb begin
        ev = EV_NONE;
        if (one_rise && !rails_s.zero)      ev = EV_ONE;
        else if (zero_rise && !rails_s.one) ev = EV_ZERO;
    end

    assert_both_high_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rails_s.one && rails_s.zero) |-> ev == EV_NONE);

    assert_event_needs_activity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_NONE) |-> activity);

endmodule

// File: rtl/a429_gap_timer.sv
// Module a429_gap_timer
// Counts rising edges of the synchronised gap clock while the line is null
// and pulses end-of-word when the count reaches GAP_LEN.
// Assumes: gap clock is much slower than clk, so edges are not missed.
module a429_gap_timer #(
    parameter int GAP_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_s,
    input  logic activity,
    output logic eow
);

    localparam int GW = $clog2(GAP_LEN + 1);

    logic          gap_q;
    logic          gap_rise;
    logic [GW-1:0] cnt;

    assign gap_rise = gap_s & ~gap_q;

    // Track the gap clock level and count null-time edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= 1'b0;
            cnt   <= '0;
            eow   <= 1'b0;
        end else begin
            gap_q <= gap_s;
            eow   <= !activity && gap_rise && (cnt == GW'(GAP_LEN - 1));
            if (activity)
                cnt <= '0;
            else if (gap_rise && cnt != GW'(GAP_LEN))
                cnt <= cnt + 1'b1;
        end
    end

    assert_gap_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= GW'(GAP_LEN));

    assert_activity_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> cnt == '0);

    assert_eow_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eow |-> cnt == GW'(GAP_LEN));

endmodule

// File: rtl/a429_word_asm.sv
// Module a429_word_asm
// Shifts bit events into a word register, counts bits, accumulates parity,
// and loads the receive buffer with error status at end of word.
// Assumes: bits arrive first-bit-first. A bit arriving in the cycle of
// end-of-word belongs to the next word.
module a429_word_asm
    import a429_rx_pkg::*;
#(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bit_ev_e              ev,
    input  logic                 eow,
    input  logic                 parity_en,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid,
    output logic                 word_err
);

    localparam int CNT_W = $clog2(WORD_BITS) + 2;

    logic [WORD_BITS-1:0] shreg, sh_base, sh_next;
    logic [CNT_W-1:0]     bitcnt, cnt_base, cnt_next;
    logic                 par_acc, par_base, par_next;
    logic                 load;
    logic                 bit_val;
    logic                 par_fail;
    logic                 cnt_bad;
    logic [WORD_BITS-1:0] final_word;

    assign load     = eow && (bitcnt != '0);
    assign bit_val  = (ev == EV_ONE);
    assign par_fail = parity_en && !par_acc;
    assign cnt_bad  = (bitcnt != CNT_W'(WORD_BITS));

    // Final word: bit WORD_BITS-1 is the parity error bit when parity is on
    always_comb begin
        final_word = shreg;
        if (parity_en) final_word[WORD_BITS-1] = par_fail;
    end

    // Next shift, count and parity: clear on load, then absorb any new bit
    always_comb begin
        sh_base  = load ? '0 : shreg;
        cnt_base = load ? '0 : bitcnt;
        par_base = load ? 1'b0 : par_acc;
        sh_next  = sh_base;
        cnt_next = cnt_base;
        par_next = par_base;
        if (ev != EV_NONE) begin
            sh_next  = {bit_val, sh_base[WORD_BITS-1:1]};
            cnt_next = (cnt_base == '1) ? cnt_base : cnt_base + 1'b1;
            par_next = par_base ^ bit_val;
        end
    end

    // Register the assembly state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            par_acc <= 1'b0;
        end else begin
            shreg   <= sh_next;
            bitcnt  <= cnt_next;
            par_acc <= par_next;
        end
    end

    // Load the receive buffer and flags at end of word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            word_err   <= 1'b0;
        end else begin
            word_valid <= load;
            if (load) begin
                word_out <= final_word;
                word_err <= cnt_bad || par_fail;
            end
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_no_empty_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eow && bitcnt == '0) |=> !word_valid);

    assert_count_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eow && bitcnt != '0 && bitcnt != CNT_W'(WORD_BITS)) |=> (word_valid && word_err));

    assert_parity_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eow && bitcnt == CNT_W'(WORD_BITS) && parity_en && !par_acc)
        |=> (word_err && word_out[WORD_BITS-1]));

    assert_parity_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eow && bitcnt == CNT_W'(WORD_BITS) && !parity_en)
        |=> (!word_err && word_out == $past(shreg)));

    assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

endmodule

// File: rtl/a429_word_rx.sv
// Module a429_word_rx
// ARINC 429 two-rail serial word receiver: synchroniser, bit detector,
// gap timer and word assembler.
// Assumes: rails and gap clock are asynchronous and slower than clk by
// several cycles per level.
module a429_word_rx #(
    parameter int WORD_BITS   = 32,
    parameter int GAP_LEN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rail_one,
    input  logic                 rail_zero,
    input  logic                 gap_clk,
    input  logic                 parity_en,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid,
    output logic                 word_err
);
    import a429_rx_pkg::*;

    logic [2:0] sync_q;
    rails_t     rails_s;
    logic       gap_s;
    bit_ev_e    ev;
    logic       activity;
    logic       eow;

    a429_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gap_clk, rail_one, rail_zero}),
        .q     (sync_q)
    );

    assign rails_s.one  = sync_q[1];
    assign rails_s.zero = sync_q[0];
    assign gap_s        = sync_q[2];

    a429_bit_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .rails_s  (rails_s),
        .ev       (ev),
        .activity (activity)
    );

    a429_gap_timer #(.GAP_LEN(GAP_LEN)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .gap_s    (gap_s),
        .activity (activity),
        .eow      (eow)
    );

    a429_word_asm #(.WORD_BITS(WORD_BITS)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .eow        (eow),
        .parity_en  (parity_en),
        .word_out   (word_out),
        .word_valid (word_valid),
        .word_err   (word_err)
    );

endmodule

// File: tb/sim_a429_word_rx.sv
`timescale 1ns/1ps
module sim_a429_word_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rail_one = 1'b0;
    logic        rail_zero = 1'b0;
    logic        gap_clk = 1'b0;
    logic        parity_en = 1'b0;
    logic [31:0] word_out;
    logic        word_valid;
    logic        word_err;

    int          n_chk = 0;
    int          n_bad = 0;
    int          n_val = 0;
    logic [31:0] cap_w = '0;
    logic        cap_e = 1'b0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    a429_word_rx u0 (
        .clk(clk), .rst_n(rst_n), .rail_one(rail_one), .rail_zero(rail_zero),
        .gap_clk(gap_clk), .parity_en(parity_en),
        .word_out(word_out), .word_valid(word_valid), .word_err(word_err)
    );

    // Capture every valid pulse away from the active edge
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            n_val++;
            cap_w = word_out;
            cap_e = word_err;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        if (b) rail_one = 1'b1; else rail_zero = 1'b1;
        repeat (3) @(negedge clk);
        rail_one = 1'b0; rail_zero = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_invalid();
        @(negedge clk);
        rail_one = 1'b1; rail_zero = 1'b1;
        repeat (3) @(negedge clk);
        rail_one = 1'b0; rail_zero = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic gap(input int n);
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            gap_clk = 1'b1; repeat (4) @(negedge clk);
            gap_clk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    // Send a full word, close it, compare against computed expectation
    task automatic word_test(input string req, input logic [31:0] w, input logic pe);
        int    v0;
        logic  fail;
        logic [31:0] ew;
        v0 = n_val;
        parity_en = pe;
        fail = pe && ((^w) == 1'b0);
        ew = w;
        if (pe) ew[31] = fail;
        send_bits({32'h0, w}, 32);
        gap(16);
        check({req, " pulse"}, n_val - v0, 1);
        check({req, " word"}, cap_w, ew);
        check({req, " err"}, cap_e, fail);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        int v0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 reset word", word_out, 0);
        check("R9 reset err", word_err, 0);
        check("R9 reset valid", word_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R6: walking ones, parity off
        for (int i = 0; i < 32; i++) word_test("R1 R6 walk1", 32'h1 << i, 1'b0);
        // R5: walking ones (odd weight -> pass), walking zeros (31 ones -> pass)
        for (int i = 0; i < 32; i++) word_test("R5 walk1", 32'h1 << i, 1'b1);
        for (int i = 0; i < 32; i++) word_test("R5 walk0", ~(32'h1 << i), 1'b1);
        // R5 failing parity (even weight) and R6 extremes
        word_test("R5 zero", 32'h0, 1'b1);
        word_test("R5 ones", 32'hFFFF_FFFF, 1'b1);
        word_test("R6 ones", 32'hFFFF_FFFF, 1'b0);
        word_test("R6 zero", 32'h0, 1'b0);
        x = 32'h1234_5679;
        for (int i = 0; i < 12; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            word_test("R1 R5 R6 mix", x, i[0]);
        end

        // R4: short and long words
        parity_en = 1'b0;
        v0 = n_val; send_bits(64'h1_5555_5555, 31); gap(16);
        check("R4 short pulse", n_val - v0, 1);
        check("R4 short err", cap_e, 1);
        v0 = n_val; send_bits(64'h1_5555_5555, 33); gap(16);
        check("R4 long pulse", n_val - v0, 1);
        check("R4 long err", cap_e, 1);

        // R2: gap of 15 does not split; merged 64 bits flagged
        v0 = n_val; send_bits(64'hA5A5_A5A5, 32); gap(15);
        check("R2 gap15 no pulse", n_val - v0, 0);
        send_bits(64'h5A5A_5A5A, 32); gap(16);
        check("R2 merged pulse", n_val - v0, 1);
        check("R2 R4 merged err", cap_e, 1);

        // R3: gap without bits gives no pulse
        v0 = n_val; gap(20);
        check("R3 idle no pulse", n_val - v0, 0);

        // R7: both rails high mid-word is ignored
        v0 = n_val;
        send_bits(64'h0000_C3C3, 16); send_invalid(); send_bits(64'h0000_8181, 16); gap(16);
        check("R7 pulse", n_val - v0, 1);
        check("R7 word", cap_w, 32'h8181_C3C3);
        check("R7 err", cap_e, 0);

        // R8: buffer held while next word arrives
        word_test("R8 first", 32'hDEAD_BEEF, 1'b0);
        send_bits(64'h0000_1234, 16);
        check("R8 hold word", word_out, 32'hDEAD_BEEF);
        send_bits(64'h0000_9ABC, 16); gap(16);
        check("R8 next word", cap_w, 32'h9ABC_1234);

        // R9: reset mid-word discards partial bits and clears buffer
        send_bits(64'h3FF, 10);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 mid reset word", word_out, 0);
        check("R9 mid reset err", word_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        word_test("R9 after reset", 32'h0F0F_1E1E, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule